// File: doc/BRIEF.md
# UART Receive Path with Line Status

This block turns an asynchronous serial line into bytes. It is paced by a sample strobe that runs at sixteen times the bit rate and takes its frame shape (five to eight data bits, parity on or off, even, odd or forced parity) from configuration inputs. The line is first brought into the clock domain through a short synchronizer. A falling edge is confirmed as a start bit at the centre of the bit time, and every later bit is sampled one bit time after the one before it.

Each finished character goes into a sixteen-entry receive queue, together with its parity and stop-bit checks. Software drains the queue through a pop strobe and watches five status outputs. The data-ready output follows queue occupancy. The four error flags stay set until a status read clears them. A line held low for a whole frame is reported as a break: one zero byte is queued and the receiver waits for the line to go idle before it looks for the next start bit.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, data_ready, parity_err, framing_err, overrun_err and break_det are all 0.
- R2: A low pulse on rx_serial is taken as a start bit only if the line is still 0 on the 8th sample tick after the tick that saw it fall. A shorter pulse leaves no character behind.
- R3: Data bits arrive least significant bit first. cfg_len selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of rd_byte read as 0.
- R4: When cfg_par_en is 1, one parity bit follows the data. With cfg_par_stick at 0, cfg_par_even 1 expects even parity and 0 expects odd. With cfg_par_stick at 1, the expected bit is the inverse of cfg_par_even. A mismatch sets parity_err and the byte is still queued.
- R5: A stop bit sampled as 0, in a frame that is not a break, sets framing_err and the byte is still queued.
- R6: The queue holds 16 characters in arrival order. rd_byte shows the oldest one and a one-cycle rd_pop removes it. data_ready is 1 exactly while the queue is not empty.
- R7: A character that completes while the queue is full is dropped and sets overrun_err. The queued characters and their order are unchanged.
- R8: A one-cycle lsr_read clears parity_err, framing_err, overrun_err and break_det on the next clock edge. It does not change data_ready. Without a read, each flag stays set.
- R9: A frame in which start, data, parity (if enabled) and stop bits are all 0 sets break_det, queues a single 0x00 byte, and sets neither parity_err nor framing_err. No further character is taken until the line has returned to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_serial | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Word length select, 5 to 8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select, or inverted forced value |
| cfg_par_stick | input | 1 | Forced parity select |
| rd_pop | input | 1 | Remove the oldest queued byte |
| lsr_read | input | 1 | Status read strobe, clears error flags |
| rd_byte | output | 8 | Oldest queued byte |
| data_ready | output | 1 | Queue not empty |
| parity_err | output | 1 | Sticky parity error |
| framing_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun error |
| break_det | output | 1 | Sticky break indication |

## Verification
The bench builds the block with its defaults: 16 samples per bit, a 16-entry queue and a two-stage synchronizer, with the sample strobe every fourth clock. Because the queue is only 16 deep, a full queue and an overrun take just seventeen frames, so the full condition is reached well inside the run. Ticks four clocks apart also leave room for the synchronizer delay while the bench still samples each bit near its centre. All four word lengths and all parity modes are reached through random frames that flip parity at random.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRKWAIT
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       par_err;
    logic       frm_err;
    logic       brk;
  } rx_frame_t;

  // index of the last data bit: 4 for 5-bit words up to 7 for 8-bit words
  function automatic logic [2:0] last_bit_idx(input logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

  // bits shift in from the top, so a short word sits high and must move down
  function automatic logic [7:0] align_data(input logic [7:0] sh, input logic [1:0] len);
    return sh >> (3'd3 - {1'b0, len});
  endfunction

  function automatic logic expected_parity(input logic [7:0] d, input logic [1:0] len,
                                           input logic even, input logic stick);
    logic [7:0] mask;
    logic       odd_ones;
    mask     = 8'hFF >> (3'd3 - {1'b0, len});
    odd_ones = ^(d & mask);
    if (stick) return ~even;
    return even ? odd_ones : ~odd_ones;
  endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx_line,
  input  logic [1:0] cfg_len,
  input  logic      cfg_par_en,
  input  logic      cfg_par_even,
  input  logic      cfg_par_stick,
  output logic      frame_valid,
  output rx_frame_t frame,
  output logic      start_reject
);

  localparam int CW = (OS_RATE > 2) ? $clog2(OS_RATE) : 1;
  localparam logic [CW-1:0] MID_CNT  = CW'(OS_RATE / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OS_RATE - 1);

  logic line_s;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = rx_line;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= (sr << 1) | SYNC_STAGES'(rx_line);
      end
      assign line_s = sr[SYNC_STAGES-1];
    end
  endgenerate

  rx_state_e     state;
  logic [CW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          par_bit;
  logic          any_one;

  logic       at_mid, at_last, brk_now;
  logic [7:0] data_now;

  assign at_mid       = tick && (tcnt == MID_CNT);
  assign at_last      = tick && (tcnt == LAST_CNT);
  assign start_reject = (state == ST_START) && at_mid && line_s;
  assign brk_now      = !any_one && !line_s;
  assign data_now     = align_data(shreg, cfg_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tcnt        <= '0;
      bidx        <= '0;
      shreg       <= '0;
      par_bit     <= 1'b0;
      any_one     <= 1'b0;
      frame_valid <= 1'b0;
      frame       <= '0;
    end else begin
      frame_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tick && !line_s) begin
            state <= ST_START;
            tcnt  <= '0;
          end
        end
        ST_START: begin
          if (at_mid) begin
            tcnt <= '0;
            if (!line_s) begin
              state   <= ST_DATA;
              bidx    <= '0;
              any_one <= 1'b0;
              par_bit <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (at_last) begin
            tcnt    <= '0;
            shreg   <= {line_s, shreg[7:1]};
            any_one <= any_one | line_s;
            if (bidx == last_bit_idx(cfg_len)) begin
              state <= cfg_par_en ? ST_PAR : ST_STOP;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_last) begin
            tcnt    <= '0;
            par_bit <= line_s;
            any_one <= any_one | line_s;
            state   <= ST_STOP;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_last) begin
            tcnt          <= '0;
            frame_valid   <= 1'b1;
            frame.data    <= data_now;
            frame.brk     <= brk_now;
            frame.frm_err <= !line_s && !brk_now;
            frame.par_err <= cfg_par_en && !brk_now &&
                             (par_bit != expected_parity(data_now, cfg_len,
                                                         cfg_par_even, cfg_par_stick));
            state         <= brk_now ? ST_BRKWAIT : ST_IDLE;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_BRKWAIT: begin
          if (line_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_glitch_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> (state == ST_IDLE && !frame_valid));

  assert_brk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRKWAIT && !line_s) |=> (state == ST_BRKWAIT && !frame_valid));

  assert_brk_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame.brk) |-> (frame.data == 8'h00 && !frame.par_err && !frame.frm_err));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0]   LAST_PTR = PW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CNTW-1:0]  count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= next_ptr(wptr);
      if (do_pop)  rptr <= next_ptr(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  assert_keep_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && $stable(rdata) && $stable(rptr)));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pe,
  input  logic set_fe,
  input  logic set_oe,
  input  logic set_bi,
  input  logic lsr_read,
  output logic pe_flag,
  output logic fe_flag,
  output logic oe_flag,
  output logic bi_flag
);

  // a new event in the read cycle wins over the clear
  function automatic logic next_flag(input logic cur, input logic set, input logic rd);
    return set | (cur & ~rd);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_flag <= 1'b0;
      fe_flag <= 1'b0;
      oe_flag <= 1'b0;
      bi_flag <= 1'b0;
    end else begin
      pe_flag <= next_flag(pe_flag, set_pe, lsr_read);
      fe_flag <= next_flag(fe_flag, set_fe, lsr_read);
      oe_flag <= next_flag(oe_flag, set_oe, lsr_read);
      bi_flag <= next_flag(bi_flag, set_bi, lsr_read);
    end
  end

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_read && !set_pe && !set_fe && !set_oe && !set_bi) |=>
      (!pe_flag && !fe_flag && !oe_flag && !bi_flag));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsr_read && (pe_flag || oe_flag)) |=> (pe_flag || oe_flag));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rx_serial,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_stick,
  input  logic       rd_pop,
  input  logic       lsr_read,
  output logic [7:0] rd_byte,
  output logic       data_ready,
  output logic       parity_err,
  output logic       framing_err,
  output logic       overrun_err,
  output logic       break_det
);

  logic      frame_valid, start_reject;
  rx_frame_t frame;
  logic      fifo_empty, fifo_full;
  logic      accept_evt, overrun_evt;

  uart_rx_sampler #(
    .OS_RATE(OS_RATE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sampler (
    .clk(clk),
    .rst_n(rst_n),
    .tick(sample_tick),
    .rx_line(rx_serial),
    .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick),
    .frame_valid(frame_valid),
    .frame(frame),
    .start_reject(start_reject)
  );

  assign accept_evt  = frame_valid && !fifo_full;
  assign overrun_evt = frame_valid && fifo_full;

  uart_rx_fifo #(
    .WIDTH(8),
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk(clk),
    .rst_n(rst_n),
    .push(frame_valid),
    .wdata(frame.data),
    .pop(rd_pop),
    .rdata(rd_byte),
    .empty(fifo_empty),
    .full(fifo_full)
  );

  uart_rx_status u_status (
    .clk(clk),
    .rst_n(rst_n),
    .set_pe(accept_evt && frame.par_err),
    .set_fe(accept_evt && frame.frm_err),
    .set_oe(overrun_evt),
    .set_bi(accept_evt && frame.brk),
    .lsr_read(lsr_read),
    .pe_flag(parity_err),
    .fe_flag(framing_err),
    .oe_flag(overrun_err),
    .bi_flag(break_det)
  );

  assign data_ready = !fifo_empty;

  assert_ready_after_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> data_ready);

  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> overrun_err);

  assert_reject_no_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |-> !frame_valid);

endmodule

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       rx_serial = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_stick = 1'b0;
  logic       rd_pop = 1'b0;
  logic       lsr_read = 1'b0;
  logic [7:0] rd_byte;
  logic       data_ready, parity_err, framing_err, overrun_err, break_det;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  uart_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_serial(rx_serial),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .rd_pop(rd_pop), .lsr_read(lsr_read),
    .rd_byte(rd_byte), .data_ready(data_ready), .parity_err(parity_err),
    .framing_err(framing_err), .overrun_err(overrun_err), .break_det(break_det)
  );

  always #5 clk = ~clk;

  initial begin
    int tcnt;
    tcnt = 0;
    forever begin
      @(posedge clk);
      sample_tick <= (tcnt == 3);
      tcnt = (tcnt + 1) % 4;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=%0d expected<=150000 cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!sample_tick) @(negedge clk);
    end
  endtask

  function automatic logic [7:0] mask_len(input logic [7:0] d, input logic [1:0] len);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 8; i++) if (i < 5 + int'(len)) r[i] = d[i];
    return r;
  endfunction

  function automatic logic ref_parity(input logic [7:0] d, input logic [1:0] len,
                                      input logic even, input logic stick);
    int ones;
    ones = 0;
    for (int i = 0; i < 5 + int'(len); i++) if (d[i]) ones++;
    if (stick) return even ? 1'b0 : 1'b1;
    if (even) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_val);
    rx_serial = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 5 + int'(cfg_len); i++) begin
      rx_serial = d[i];
      wait_ticks(16);
    end
    if (cfg_par_en) begin
      rx_serial = ref_parity(d, cfg_len, cfg_par_even, cfg_par_stick) ^ flip_par;
      wait_ticks(16);
    end
    rx_serial = stop_val;
    wait_ticks(16);
    rx_serial = 1'b1;
    wait_ticks(16);
  endtask

  task automatic pop_byte(output logic [7:0] b);
    @(negedge clk);
    b = rd_byte;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic read_lsr();
    @(negedge clk);
    lsr_read = 1'b1;
    @(negedge clk);
    lsr_read = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] b;
    logic [7:0] q [16];
    void'($urandom(32'h5EED_1234));

    repeat (5) @(negedge clk);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 parity_err", parity_err, 0);
    chk("R1 framing_err", framing_err, 0);
    chk("R1 overrun_err", overrun_err, 0);
    chk("R1 break_det", break_det, 0);
    rst_n = 1'b1;
    wait_ticks(20);

    // R3: 8-bit word, no parity
    send_frame(8'hA5, 1'b0, 1'b1);
    chk("R6 ready after frame", data_ready, 1);
    pop_byte(b);
    chk("R3 8-bit byte", b, 8'hA5);
    chk("R6 empty after pop", data_ready, 0);
    chk("R5 no framing error", framing_err, 0);

    // R3: 5-bit word keeps upper bits zero
    cfg_len = 2'b00;
    send_frame(8'hFF, 1'b0, 1'b1);
    pop_byte(b);
    chk("R3 5-bit byte", b, 8'h1F);
    cfg_len = 2'b11;

    // R2: short low pulse is not a start bit
    rx_serial = 1'b0;
    wait_ticks(4);
    rx_serial = 1'b1;
    wait_ticks(200);
    chk("R2 glitch ignored", data_ready, 0);
    chk("R2 no framing error", framing_err, 0);

    // R4: odd parity with wrong bit
    cfg_par_en = 1'b1;
    cfg_par_even = 1'b0;
    send_frame(8'h3C, 1'b1, 1'b1);
    chk("R4 parity error set", parity_err, 1);
    chk("R4 byte still queued", data_ready, 1);
    read_lsr();
    chk("R8 parity cleared by read", parity_err, 0);
    chk("R8 ready kept by read", data_ready, 1);
    pop_byte(b);
    chk("R4 byte with bad parity", b, 8'h3C);

    // R4: forced parity, correct bit
    cfg_par_stick = 1'b1;
    cfg_par_even = 1'b1;
    send_frame(8'h81, 1'b0, 1'b1);
    chk("R4 forced parity ok", parity_err, 0);
    pop_byte(b);
    chk("R4 forced parity byte", b, 8'h81);
    cfg_par_stick = 1'b0;
    cfg_par_en = 1'b0;

    // R5: stop bit low
    send_frame(8'h5A, 1'b0, 1'b0);
    chk("R5 framing error set", framing_err, 1);
    chk("R9 not a break", break_det, 0);
    wait_ticks(40);
    chk("R8 framing error sticky", framing_err, 1);
    pop_byte(b);
    chk("R5 byte queued", b, 8'h5A);
    chk("R5 single byte", data_ready, 0);
    read_lsr();
    chk("R8 framing cleared", framing_err, 0);

    // R6, R7: fill, overrun, drain in order
    for (int i = 0; i < 16; i++) begin
      q[i] = 8'($urandom);
      send_frame(q[i], 1'b0, 1'b1);
    end
    chk("R6 ready when full", data_ready, 1);
    chk("R7 no overrun yet", overrun_err, 0);
    send_frame(8'hEE, 1'b0, 1'b1);
    chk("R7 overrun set", overrun_err, 1);
    for (int i = 0; i < 16; i++) begin
      pop_byte(b);
      chk("R6 R7 order kept", b, q[i]);
    end
    chk("R6 empty after drain", data_ready, 0);
    chk("R8 overrun sticky", overrun_err, 1);
    read_lsr();
    chk("R8 overrun cleared", overrun_err, 0);

    // R9: break
    rx_serial = 1'b0;
    wait_ticks(16 * 10 + 64);
    chk("R9 break set", break_det, 1);
    chk("R9 no framing error", framing_err, 0);
    chk("R9 no parity error", parity_err, 0);
    chk("R9 one byte queued", data_ready, 1);
    pop_byte(b);
    chk("R9 zero byte", b, 8'h00);
    wait_ticks(40);
    chk("R9 single byte while low", data_ready, 0);
    rx_serial = 1'b1;
    wait_ticks(20);
    read_lsr();
    chk("R8 break cleared", break_det, 0);
    send_frame(8'h77, 1'b0, 1'b1);
    pop_byte(b);
    chk("R9 resumes after idle", b, 8'h77);

    // random frames across lengths and parity modes
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d;
      logic flip;
      cfg_len       = 2'($urandom);
      cfg_par_en    = 1'($urandom);
      cfg_par_even  = 1'($urandom);
      cfg_par_stick = 1'($urandom);
      d    = 8'($urandom);
      flip = cfg_par_en && (($urandom % 3) == 0);
      send_frame(d, flip, 1'b1);
      chk("R4 random parity flag", parity_err, flip);
      chk("R5 random framing flag", framing_err, 0);
      pop_byte(b);
      chk("R3 random byte", b, mask_len(d, cfg_len));
      read_lsr();
      chk("R8 random clear", parity_err, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule